// File: doc/BRIEF.md
# Link Command Mailbox and Phase Controller

This block sits between a host register interface and the phase state machine of a serial link controller. The host posts a 6-bit command code into a 16-bit mailbox register. In the same write it sets an "available" flag. On the next cycle the controller checks the command against the link's current phase. A legal command moves the link to its new phase. A command that conflicts with the phase leaves the phase as it was and sets a sticky error flag. In both cases the controller clears the available flag, which tells the host that the mailbox is free again.

The link has three phases: powered off, out of service and in service. The only path up from powered off is initialize, then power on, then start. Power-off is legal from either active phase and clears the initialized state. The phase drives three line controls: a DMA enable, a force-all-ones request to the transmitter and a discard request to the receiver. Each phase change posts a 6-bit indication code in the low byte of the register, together with a one-cycle strobe for the interrupt logic.

Top module: `lnk_cmd_ctrl`

## Requirements
- R1: After reset the phase is powered off (code 0), and the error flag, the available flag, the command field and the indication field are all zero.
- R2: The register reads as follows: error at bit 15, available at bit 14, command at bits 13:8, zeros at bits 7:6 and the indication at bits 5:0. A write with bit 14 set loads the command and sets the available flag when the next clock edge is taken. The command is processed on the following edge, and the available flag clears on that same edge.
- R3: While the available flag is set, host writes change neither the command field nor the available flag.
- R4: Command 0x01 (initialize) is accepted only in powered off, where it sets an internal initialized state. In any other phase it is a conflict.
- R5: Command 0x02 (power on) is accepted only in powered off with the initialized state set, and it moves the link to out of service (code 1). Otherwise it is a conflict.
- R6: Command 0x03 (start) is accepted only in out of service, and it moves the link to in service (code 2). Otherwise it is a conflict.
- R7: Command 0x04 (power off) is accepted in out of service and in service. It moves the link to powered off and clears the initialized state. In powered off it is a conflict.
- R8: Any other command code is a conflict. A conflict sets the error flag and leaves the phase unchanged.
- R9: The error flag is sticky. Writing a 1 to bit 15 clears it, and writing a 0 has no effect. If a new conflict arrives on the same edge as a clear, the flag stays set.
- R10: In powered off, DMA enable is 0 and the all-ones and receive-discard outputs are 1. In the other phases, DMA enable is 1 and the other two outputs are 0.
- R11: On every phase change the indication field takes 0x10 plus the new phase code, and the strobe is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host register write strobe |
| wr_data_i | input | 16 | Host write data |
| reg_o | output | 16 | Register read value |
| phase_o | output | 2 | Current link phase |
| dma_en_o | output | 1 | DMA enable |
| tx_ones_o | output | 1 | Transmitter sends continuous ones |
| rx_ignore_o | output | 1 | Receiver discards incoming data |
| ind_o | output | 6 | Provider indication code |
| ind_stb_o | output | 1 | One-cycle strobe for a new indication |

## Verification
The sweep issues every one of the 64 command codes from each of four starting states: powered off without initialization, powered off with initialization, out of service and in service. This separates the phase gating of each legal command from the rejection of unknown codes, and it shows whether power on depends on the initialized state. Directed sequences cover the cases the sweep cannot reach. A second write is made while the first command is still pending. The error flag gets a write of zero, a write of one, and a clear that lands on the same edge as a new conflict.

// File: rtl/lnk_cmd_pkg.sv
package lnk_cmd_pkg;
  localparam int CMD_W   = 6;
  localparam int REG_W   = 16;
  localparam int ERR_BIT = 15;
  localparam int AVL_BIT = 14;
  localparam int CMD_LSB = 8;
  localparam int IND_W   = CMD_W;

  typedef enum logic [1:0] {
    PH_OFF = 2'd0,
    PH_OOS = 2'd1,
    PH_INS = 2'd2
  } phase_e;

  localparam logic [CMD_W-1:0] CMD_INIT    = 6'h01;
  localparam logic [CMD_W-1:0] CMD_PWR_ON  = 6'h02;
  localparam logic [CMD_W-1:0] CMD_START   = 6'h03;
  localparam logic [CMD_W-1:0] CMD_PWR_OFF = 6'h04;

  localparam logic [IND_W-1:0] IND_BASE = 6'h10;
endpackage

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import lnk_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             done_i,
  input  logic             err_set_i,
  output logic             avail_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             err_o
);
  logic             avail_q, err_q;
  logic [CMD_W-1:0] cmd_q;
  logic             load, clr;

  assign load = wr_en_i && wr_data_i[AVL_BIT] && !avail_q;
  assign clr  = wr_en_i && wr_data_i[ERR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avail_q <= 1'b0;
      cmd_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      if (load) begin
        avail_q <= 1'b1;
        cmd_q   <= wr_data_i[CMD_LSB +: CMD_W];
      end else if (done_i) begin
        avail_q <= 1'b0;
      end
      // new conflict wins over a same-cycle clear
      if (err_set_i)  err_q <= 1'b1;
      else if (clr)   err_q <= 1'b0;
    end
  end

  assign avail_o = avail_q;
  assign cmd_o   = cmd_q;
  assign err_o   = err_q;

  AST_AVAIL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_q |=> !avail_q); // R2
  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_q |=> $stable(cmd_q)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(wr_en_i && wr_data_i[ERR_BIT])) |=> err_q); // R9
endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
  import lnk_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             avail_i,
  input  logic [CMD_W-1:0] cmd_i,
  output phase_e           phase_o,
  output phase_e           nxt_o,
  output logic             chg_o,
  output logic             done_o,
  output logic             err_set_o
);
  phase_e phase_q, phase_d;
  logic   init_q, init_d, ok;

  always_comb begin
    ok      = 1'b0;
    phase_d = phase_q;
    init_d  = init_q;
    if (avail_i) begin
      case (cmd_i)
        CMD_INIT:    if (phase_q == PH_OFF) begin
                       ok = 1'b1; init_d = 1'b1;
                     end
        CMD_PWR_ON:  if (phase_q == PH_OFF && init_q) begin
                       ok = 1'b1; phase_d = PH_OOS;
                     end
        CMD_START:   if (phase_q == PH_OOS) begin
                       ok = 1'b1; phase_d = PH_INS;
                     end
        CMD_PWR_OFF: if (phase_q != PH_OFF) begin
                       ok = 1'b1; phase_d = PH_OFF; init_d = 1'b0;
                     end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OFF;
      init_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      init_q  <= init_d;
    end
  end

  assign phase_o   = phase_q;
  assign nxt_o     = phase_d;
  assign chg_o     = (phase_d != phase_q);
  assign done_o    = avail_i;
  assign err_set_o = avail_i && !ok;

  AST_PHASE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q != 2'd3); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avail_i |=> $stable(phase_q)); // R8
  AST_ORDER_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_OOS && $past(phase_q) == PH_OFF) |-> $past(init_q)); // R5
  AST_INIT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_OFF && $past(phase_q) != PH_OFF) |-> !init_q); // R7
endmodule

// File: rtl/ind_post.sv
module ind_post
  import lnk_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chg_i,
  input  phase_e           nxt_i,
  output logic [IND_W-1:0] ind_o,
  output logic             stb_o
);
  logic [IND_W-1:0] ind_q;
  logic             stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ind_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= chg_i;
      if (chg_i) ind_q <= IND_BASE + IND_W'(nxt_i);
    end
  end

  assign ind_o = ind_q;
  assign stb_o = stb_q;
endmodule

// File: rtl/lnk_cmd_ctrl.sv
module lnk_cmd_ctrl
  import lnk_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] reg_o,
  output logic [1:0]  phase_o,
  output logic        dma_en_o,
  output logic        tx_ones_o,
  output logic        rx_ignore_o,
  output logic [5:0]  ind_o,
  output logic        ind_stb_o
);
  localparam int PAD_W = CMD_LSB - IND_W;

  logic             avail, err, done, err_set, chg;
  logic [CMD_W-1:0] cmd;
  phase_e           phase, nxt;

  cmd_mailbox u_mbox (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .done_i(done), .err_set_i(err_set),
    .avail_o(avail), .cmd_o(cmd), .err_o(err)
  );

  phase_fsm u_fsm (
    .clk_i, .rst_ni, .avail_i(avail), .cmd_i(cmd),
    .phase_o(phase), .nxt_o(nxt), .chg_o(chg),
    .done_o(done), .err_set_o(err_set)
  );

  ind_post u_ind (
    .clk_i, .rst_ni, .chg_i(chg), .nxt_i(nxt),
    .ind_o(ind_o), .stb_o(ind_stb_o)
  );

  always_comb begin
    reg_o                        = '0;
    reg_o[ERR_BIT]               = err;
    reg_o[AVL_BIT]               = avail;
    reg_o[CMD_LSB +: CMD_W]      = cmd;
    reg_o[IND_W +: PAD_W]        = '0;
    reg_o[0 +: IND_W]            = ind_o;
  end

  assign phase_o     = phase;
  assign dma_en_o    = (phase != PH_OFF);
  assign tx_ones_o   = (phase == PH_OFF);
  assign rx_ignore_o = (phase == PH_OFF);

  AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ind_stb_o |=> !ind_stb_o); // R11
  AST_STB_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != $past(phase_o)) |-> ind_stb_o); // R11
  AST_IND_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ind_stb_o |-> (ind_o == IND_BASE + IND_W'(phase_o))); // R11
  AST_OFF_NO_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ones_o |-> (!dma_en_o && rx_ignore_o)); // R10
endmodule

// File: tb/tb_lnk_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_lnk_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] reg_o;
  logic [1:0]  phase_o;
  logic        dma_en_o, tx_ones_o, rx_ignore_o, ind_stb_o;
  logic [5:0]  ind_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lnk_cmd_ctrl dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_data_i, .reg_o, .phase_o,
    .dma_en_o, .tx_ones_o, .rx_ignore_o, .ind_o, .ind_stb_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
  end

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    @(negedge clk); rst_ni = 1'b1;
  endtask

  // write command, check pending state, return after processing edge
  task automatic issue(input logic [5:0] code);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = {2'b01, code, 8'h00};
    @(negedge clk); wr_en_i = 1'b0;
    check("R2 avail set", int'(reg_o[14]), 1);
    check("R2 cmd field", int'(reg_o[13:8]), int'(code));
    @(negedge clk);
    check("R2 avail cleared", int'(reg_o[14]), 0);
  endtask

  // reference model from the requirements
  function automatic void model(input int ph, input bit ini, input int code,
                                output int nph, output bit nini, output bit er);
    nph = ph; nini = ini; er = 1'b0;
    case (code)
      1: if (ph == 0) nini = 1'b1; else er = 1'b1;
      2: if (ph == 0 && ini) nph = 1; else er = 1'b1;
      3: if (ph == 1) nph = 2; else er = 1'b1;
      4: if (ph != 0) begin nph = 0; nini = 1'b0; end else er = 1'b1;
      default: er = 1'b1;
    endcase
  endfunction

  function automatic string req_of(input int code);
    case (code)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    int nph; bit nini, er;
    int ph; bit ini;
    // R1 reset state
    @(negedge clk); @(negedge clk);
    check("R1 phase", int'(phase_o), 0);
    check("R1 reg", int'(reg_o), 0);
    check("R1 ind", int'(ind_o), 0);
    rst_ni = 1'b1;

    // sweep: every code from every start state
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 64; c++) begin
        do_reset();
        ph = 0; ini = 1'b0;
        if (s >= 1) begin issue(6'h01); ini = 1'b1; end
        if (s >= 2) begin issue(6'h02); ph = 1; end
        if (s >= 3) begin issue(6'h03); ph = 2; end
        @(negedge clk);
        model(ph, ini, c, nph, nini, er);
        issue(6'(c));
        check({req_of(c), " phase"}, int'(phase_o), nph);
        check({req_of(c), " err"}, int'(reg_o[15]), int'(er));
        check("R11 strobe", int'(ind_stb_o), int'(nph != ph));
        if (nph != ph) check("R11 ind", int'(ind_o), 16 + nph);
        check("R2 pad bits", int'(reg_o[7:6]), 0);
        check("R10 dma", int'(dma_en_o), int'(nph != 0));
        check("R10 ones", int'(tx_ones_o), int'(nph == 0));
        check("R10 rx ignore", int'(rx_ignore_o), int'(nph == 0));
        @(negedge clk);
        check("R11 strobe width", int'(ind_stb_o), 0);
        // R5/R7: after init then power on then power off, power on needs a fresh init
        if (s == 2 && c == 4) begin
          issue(6'h02);
          check("R7 init cleared", int'(phase_o), 0);
        end
      end
    end

    // R3 write while pending is ignored
    do_reset();
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = {2'b01, 6'h01, 8'h00};
    @(negedge clk); wr_data_i = {2'b01, 6'h3F, 8'h00};
    @(negedge clk); wr_en_i = 1'b0;
    check("R3 cmd kept", int'(reg_o[13:8]), 1);
    check("R3 no err", int'(reg_o[15]), 0);
    check("R3 avail", int'(reg_o[14]), 0);

    // R9 sticky error
    do_reset();
    issue(6'h3F);
    check("R9 err set", int'(reg_o[15]), 1);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 16'h0000;
    @(negedge clk); wr_en_i = 1'b0;
    check("R9 write zero", int'(reg_o[15]), 1);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 16'h8000;
    @(negedge clk); wr_en_i = 1'b0;
    check("R9 write one", int'(reg_o[15]), 0);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = {2'b01, 6'h3F, 8'h00};
    @(negedge clk); wr_data_i = 16'h8000;
    @(negedge clk); wr_en_i = 1'b0;
    check("R9 set beats clear", int'(reg_o[15]), 1);

    report();
  end
endmodule